// File: doc/BRIEF.md
# Register Rename Table with Integrated Tag Free List

This block keeps the speculative mapping from architectural register numbers to physical register tags for one register class of an out-of-order core. Every architectural register owns one entry holding the physical tag it currently names. A pool of unused physical tags is kept in a FIFO inside the block. When an instruction writes a destination register, the block takes a fresh tag from that pool and writes it into the entry. In the same cycle it reports both the fresh tag and the tag the entry held before. Later logic frees the old tag once the writer retires.

Source operands are translated through a set of combinational lookup ports. These always show the mapping in effect at the start of the cycle, so an instruction that reads and writes the same register sees its old producer. One architectural index, chosen by a parameter, may be a hardwired zero register. It keeps its reserved tag forever and never takes anything from the pool. Setting that parameter to all ones gives a class with no zero register.

Top module: `rename_map_table`

## Requirements
- R1: After reset, architectural register i maps to physical tag i, and the lookup ports return that tag.
- R2: After reset the free pool holds tags NUM_ARCH up to NUM_PHYS-1. Successive allocations hand them out in ascending order.
- R3: A rename of a non-zero register, with the pool not empty, drives `renNewTag` to the pool head and `renPrevTag` to the entry's current tag in the same cycle. From the next cycle the entry holds the new tag.
- R4: A rename of the zero register (`ZERO_IDX`) drives both `renNewTag` and `renPrevTag` to the tag ZERO_IDX. It takes nothing from the pool, and the table does not change.
- R5: A rename of a non-zero register while the pool is empty raises `renStall` in the same cycle. Neither the table nor the pool order changes. A tag released in that same cycle is usable from the next cycle onward.
- R6: Each cycle with `relValid` high appends `relTag` to the tail of the pool. An allocation and a release in the same cycle both take effect.
- R7: The lookup ports are combinational. In a cycle that renames the same register, they return the mapping from before that rename.
- R8: With `ZERO_IDX` set to 32'hFFFF_FFFF there is no zero register, and index 0 is renamed like any other index.
- R9: The zero register's entry holds tag ZERO_IDX at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcArch | input | NUM_SRC*AW | Packed architectural indices to look up, port k in bits [k*AW +: AW] |
| srcPhys | output | NUM_SRC*PW | Packed physical tags for each lookup port |
| renValid | input | 1 | Destination rename request |
| renArch | input | AW | Architectural destination index |
| renNewTag | output | PW | Tag the destination now maps to (meaningless while stalled) |
| renPrevTag | output | PW | Tag the destination mapped to before this rename |
| renStall | output | 1 | Request refused because the pool is empty |
| relValid | input | 1 | Return a retired tag to the pool |
| relTag | input | PW | Tag being returned |

## Verification
The bench drains the pool to empty with back-to-back renames. A design with a wrong empty check would hand out a stale tag or corrupt a mapping, and the reference model exposes both. It releases a tag in the very cycle a rename stalls. It also allocates and releases together on a one-entry pool, where a design with an off-by-one count or pointer loses or duplicates a tag. Renames of the zero register are mixed into the traffic: a design that allocated for it would shift every later tag by one. Lookups of a register renamed in the same cycle catch a bypass that leaks the new tag early, and a second instance with no zero register catches an index 0 that is wrongly held fixed.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic allocPop;   // take head of pool, write table entry
    logic relPush;    // append returned tag at tail
    logic stall;      // rename refused
    logic zeroHit;    // request targets the zero register
  } rmt_stb_t;
endpackage

// File: rtl/rmt_ctrl.sv
module rmt_ctrl
  import rmt_pkg::*;
#(
  parameter int unsigned NUM_ARCH = 16,
  parameter int unsigned ZERO_IDX = 0,
  localparam int unsigned AW = $clog2(NUM_ARCH)
) (
  input  logic          renValid,
  input  logic [AW-1:0] renArch,
  input  logic          relValid,
  input  logic          freeEmpty,
  output rmt_stb_t      stb
);
  localparam bit HAS_ZERO = (ZERO_IDX != 32'hFFFF_FFFF);
  localparam logic [AW-1:0] ZERO_A = AW'(ZERO_IDX);

  logic isZero;

  generate
    if (HAS_ZERO) begin : g_zero
      assign isZero = (renArch == ZERO_A);
    end else begin : g_nozero
      assign isZero = 1'b0;
    end
  endgenerate

  always_comb begin
    stb.zeroHit  = renValid && isZero;
    stb.allocPop = renValid && !isZero && !freeEmpty;
    stb.stall    = renValid && !isZero && freeEmpty;
    stb.relPush  = relValid;
  end
endmodule

// File: rtl/rmt_datapath.sv
module rmt_datapath
  import rmt_pkg::*;
#(
  parameter int unsigned NUM_ARCH = 16,
  parameter int unsigned NUM_PHYS = 32,
  parameter int unsigned NUM_SRC  = 2,
  parameter int unsigned ZERO_IDX = 0,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rmt_stb_t              stb,
  input  logic [NUM_SRC*AW-1:0] srcArch,
  output logic [NUM_SRC*PW-1:0] srcPhys,
  input  logic [AW-1:0]         renArch,
  input  logic [PW-1:0]         relTag,
  output logic [PW-1:0]         renNewTag,
  output logic [PW-1:0]         renPrevTag,
  output logic                  freeEmpty
);
  localparam bit HAS_ZERO = (ZERO_IDX != 32'hFFFF_FFFF);
  localparam int unsigned DEPTH = NUM_PHYS;
  localparam int unsigned FREE0 = NUM_PHYS - NUM_ARCH;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned QW = $clog2(DEPTH);
  localparam logic [AW-1:0] ZERO_A = AW'(ZERO_IDX);
  localparam logic [PW-1:0] ZERO_T = PW'(ZERO_IDX);

  logic [PW-1:0] mapQ  [NUM_ARCH];
  logic [PW-1:0] poolQ [DEPTH];
  logic [QW-1:0] headQ, tailQ;
  logic [CW-1:0] countQ;
  logic [PW-1:0] headTag;

  function automatic logic [QW-1:0] nextPtr(input logic [QW-1:0] p);
    return (p == QW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headTag   = poolQ[headQ];
  assign freeEmpty = (countQ == '0);
  assign renPrevTag = mapQ[renArch];
  assign renNewTag  = stb.zeroHit ? mapQ[renArch] : headTag;

  generate
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      assign srcPhys[k*PW +: PW] = mapQ[srcArch[k*AW +: AW]];
    end
  endgenerate

  // mapping table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ARCH; i++) mapQ[i] <= PW'(i);
    end else if (stb.allocPop) begin
      mapQ[renArch] <= headTag;
    end
  end

  // free pool FIFO
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++)
        poolQ[i] <= (i < FREE0) ? PW'(NUM_ARCH + i) : '0;
      headQ  <= '0;
      tailQ  <= QW'(FREE0 % DEPTH);
      countQ <= CW'(FREE0);
    end else begin
      if (stb.relPush) begin
        poolQ[tailQ] <= relTag;
        tailQ <= nextPtr(tailQ);
      end
      if (stb.allocPop) headQ <= nextPtr(headQ);
      case ({stb.allocPop, stb.relPush})
        2'b10:   countQ <= countQ - 1'b1;
        2'b01:   countQ <= countQ + 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end

  // R6: a release may not arrive when the pool is already full
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.relPush && !stb.allocPop) |-> (countQ != CW'(DEPTH)));

  // R3: a lone allocation shrinks the pool by one
  p_alloc_take_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.allocPop && !stb.relPush) |=> (countQ == $past(countQ) - 1'b1));

  // R5: a stalled rename with no release leaves the pool untouched
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stall && !stb.relPush) |=> ($stable(countQ) && $stable(headQ)));

  // R4: a zero-register rename leaves the destination entry untouched
  p_zero_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.zeroHit |=> (mapQ[$past(renArch)] == $past(renPrevTag)));

  generate
    if (HAS_ZERO) begin : g_zchk
      // R9: zero register keeps its reserved tag
      p_zero_entry_r9: assert property (@(posedge clk) disable iff (!rstN)
        mapQ[ZERO_A] == ZERO_T);
    end
  endgenerate
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rmt_pkg::*;
#(
  parameter int unsigned NUM_ARCH = 16,
  parameter int unsigned NUM_PHYS = 32,
  parameter int unsigned NUM_SRC  = 2,
  parameter int unsigned ZERO_IDX = 0,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC*AW-1:0] srcArch,
  output logic [NUM_SRC*PW-1:0] srcPhys,
  input  logic                  renValid,
  input  logic [AW-1:0]         renArch,
  output logic [PW-1:0]         renNewTag,
  output logic [PW-1:0]         renPrevTag,
  output logic                  renStall,
  input  logic                  relValid,
  input  logic [PW-1:0]         relTag
);
  rmt_stb_t stb;
  logic freeEmpty;

  rmt_ctrl #(.NUM_ARCH(NUM_ARCH), .ZERO_IDX(ZERO_IDX)) u_ctrl (
    .renValid(renValid), .renArch(renArch), .relValid(relValid),
    .freeEmpty(freeEmpty), .stb(stb)
  );

  rmt_datapath #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS),
                 .NUM_SRC(NUM_SRC), .ZERO_IDX(ZERO_IDX)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .srcArch(srcArch), .srcPhys(srcPhys),
    .renArch(renArch), .relTag(relTag), .renNewTag(renNewTag),
    .renPrevTag(renPrevTag), .freeEmpty(freeEmpty)
  );

  assign renStall = stb.stall;
endmodule

// File: tb/sim_rename_map_table.sv
module sim_rename_map_table;
  localparam int NA = 16, NP = 32, NS = 2, AW = 4, PW = 5;

  logic clk = 0, rstN = 0;
  always #10 clk = ~clk;   // 50 MHz

  logic [NS*AW-1:0] srcArch = '0;
  logic [NS*PW-1:0] srcPhys;
  logic renValid = 0, relValid = 0, renStall;
  logic [AW-1:0] renArch = '0;
  logic [PW-1:0] renNewTag, renPrevTag, relTag = '0;

  logic renValid1 = 0, renStall1;
  logic [AW-1:0] renArch1 = '0;
  logic [PW-1:0] new1, prev1;
  logic [NS*PW-1:0] srcPhys1;

  rename_map_table #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_SRC(NS), .ZERO_IDX(0)) u0 (
    .clk(clk), .rstN(rstN), .srcArch(srcArch), .srcPhys(srcPhys),
    .renValid(renValid), .renArch(renArch), .renNewTag(renNewTag),
    .renPrevTag(renPrevTag), .renStall(renStall),
    .relValid(relValid), .relTag(relTag));

  rename_map_table #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_SRC(NS),
                     .ZERO_IDX(32'hFFFF_FFFF)) u1 (
    .clk(clk), .rstN(rstN), .srcArch(srcArch), .srcPhys(srcPhys1),
    .renValid(renValid1), .renArch(renArch1), .renNewTag(new1),
    .renPrevTag(prev1), .renStall(renStall1),
    .relValid(1'b0), .relTag('0));

  int nChk = 0, nBad = 0;
  int mapM [NA];
  int poolM [$];
  int retired [$];

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare before posedge, update model
  task automatic step(input bit rv, input int ra, input bit lv, input int lt,
                      input int s0, input int s1, input string tag);
    int prev, expNew; bit expStall;
    @(negedge clk);
    renValid = rv; renArch = AW'(ra); relValid = lv; relTag = PW'(lt);
    srcArch = {AW'(s1), AW'(s0)};
    #1;
    check({tag, " R7 lookup0"}, int'(srcPhys[PW-1:0]), mapM[s0]);
    check({tag, " R7 lookup1"}, int'(srcPhys[2*PW-1:PW]), mapM[s1]);
    prev = mapM[ra];
    expStall = rv && ra != 0 && poolM.size() == 0;
    check({tag, " R5 stall"}, int'(renStall), int'(expStall));
    if (rv) begin
      check({tag, " R3 prev"}, int'(renPrevTag), prev);
      if (ra == 0) begin
        check({tag, " R4 zero new"}, int'(renNewTag), 0);
        check({tag, " R4 zero prev"}, int'(renPrevTag), 0);
      end else if (!expStall) begin
        expNew = poolM.pop_front();
        check({tag, " R3 new"}, int'(renNewTag), expNew);
        mapM[ra] = expNew;
        retired.push_back(prev);
      end
    end
    if (lv) poolM.push_back(lt);
    @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(1234);
    for (int i = 0; i < NA; i++) mapM[i] = i;
    for (int i = NA; i < NP; i++) poolM.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1: reset mapping via lookups
    for (int i = 0; i < NA; i += 2) step(0, 0, 0, 0, i, i + 1, "R1");

    // R2: ascending allocation order
    step(1, 3, 0, 0, 3, 1, "R2 first");
    step(1, 5, 0, 0, 3, 5, "R2 second");
    // R7: rename and look up same register in same cycle
    step(1, 3, 0, 0, 3, 3, "R7 same-cycle");
    // R4: zero register consumes nothing
    step(1, 0, 0, 0, 0, 2, "R4");
    step(1, 7, 0, 0, 0, 7, "R4 after");

    // R5: drain the pool, then stall
    while (poolM.size() > 0) step(1, 1 + ($urandom % (NA - 1)), 0, 0, 1, 2, "R5 drain");
    step(1, 9, 0, 0, 9, 0, "R5 empty");
    check("R5 table held", int'(mapM[9]), mapM[9]);
    begin
      int t = retired.pop_front();
      step(1, 9, 1, t, 9, 4, "R5 stall+release");
      step(1, 9, 0, 0, 9, 4, "R5 released usable");
      // R6: alloc and release together with a one-entry pool
      t = retired.pop_front();
      step(1, 2, 1, t, 2, 9, "R6 pre");
      t = retired.pop_front();
      step(1, 4, 1, t, 2, 4, "R6 both");
      step(1, 6, 0, 0, 4, 6, "R6 after");
    end

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit rv, lv; int ra, lt;
      rv = ($urandom % 4) != 0;
      ra = (($urandom % 8) == 0) ? 0 : ($urandom % NA);
      lv = (retired.size() > 0) && (($urandom % 3) != 0);
      lt = lv ? retired.pop_front() : 0;
      step(rv, ra, lv, lt, $urandom % NA, $urandom % NA, "rand R3/R6");
    end

    // R8: instance without a zero register renames index 0
    @(negedge clk); renValid = 0; relValid = 0;
    renValid1 = 1; renArch1 = '0; #1;
    check("R8 new", int'(new1), NA);
    check("R8 prev", int'(prev1), 0);
    check("R8 stall", int'(renStall1), 0);
    @(negedge clk); renValid1 = 0; srcArch = '0; #1;
    check("R8 lookup", int'(srcPhys1[PW-1:0]), NA);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule